// File: doc/BRIEF.md
# Zoned Data-Memory Wait-State Generator

This block sits between a processor core's data-memory request port and the strobes of an external memory bus. The data address is 14 bits wide. Everything from 0x3800 up is handled on chip: internal RAM, control registers and reserved space. The rest is external and falls into five zones, and each zone has its own programmable wait-state count. For an external access the block drives the chip select, plus either the read strobe (which serves as the output enable) or the write strobe. It holds the core off with a ready signal until the zone's wait count has run out.

The core port is a valid/ready request channel. The core raises `req_valid` with an address, a direction and write data, and must hold all of them stable until it sees `req_ready` high at a clock edge. A low `req_ready` while `req_valid` is high is the stall. Read data from an external zone returns one cycle after the completing cycle, as a one-cycle `rd_valid` pulse. That return path has no back-pressure, so the core must take it. The 16-bit data ports stand for the upper 16 lanes of a 24-bit external data bus.

The wait counts are 3-bit fields, one per zone. They are written through a small configuration port, and every field starts at seven after reset.

Top module: `dmw_wait_gen`

## Requirements
- R1: The address decode places 0x0000-0x03FF in zone 0, 0x0400-0x07FF in zone 1, 0x0800-0x2FFF in zone 2, 0x3000-0x33FF in zone 3 and 0x3400-0x37FF in zone 4. Each access uses the wait count of its own zone.
- R2: An access at 0x3800 or above never drives `ext_sel_n` low. It raises `int_sel` and completes in the cycle it is presented.
- R3: After reset every zone's wait count is 7, so an external access takes 8 cycles.
- R4: An external access with wait count W holds `req_ready` low for W cycles and raises it in cycle W+1. W = 0 completes in one cycle.
- R5: `ext_sel_n` is low in every cycle of an external access, including the final one. In those cycles `ext_rd_n` is low for a read (`req_write`=0) and `ext_wr_n` is low for a write (`req_write`=1), never both. With no request, all three strobes are high.
- R6: A configuration write with `cfg_we`=1 sets the count of zone `cfg_zone` (values 0-4) to `cfg_wait` and leaves the other zones unchanged. A write with `cfg_zone` of 5, 6 or 7 is ignored.
- R7: The cycle after an external read completes, `rd_valid` is high for one cycle. `rd_data` then holds the `ext_din` value sampled in the completing cycle.
- R8: `ext_addr` follows `req_addr`. During an external write, `ext_dout` carries `req_wdata`.
- R9: The wait count is taken when an access starts. A configuration write to that zone during the access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Wait-count write enable |
| cfg_zone | input | 3 | Zone index to write (0-4 valid) |
| cfg_wait | input | 3 | New wait count |
| req_valid | input | 1 | Core access request |
| req_ready | output | 1 | Access completes this cycle (low = stall) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Data-memory address |
| req_wdata | input | 16 | Write data |
| int_sel | output | 1 | Request targets on-chip space |
| rd_valid | output | 1 | External read data valid |
| rd_data | output | 16 | External read data |
| ext_addr | output | 14 | External address |
| ext_sel_n | output | 1 | External data-memory chip select, active low |
| ext_rd_n | output | 1 | Read strobe / output enable, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_dout | output | 16 | External write data (upper bus lanes) |
| ext_din | input | 16 | External read data (upper bus lanes) |

## Verification
The assertions assume the core keeps `req_valid`, `req_addr`, `req_write` and `req_wdata` unchanged from the start of an access until `req_ready` is seen high. Without that, strobe timing and stall length have no meaning. They also assume the read return is always accepted. The bench driver applies each request one time unit after a rising edge and holds it through the completing edge. It then drops `req_valid` for at least one cycle. Configuration writes are sent at arbitrary points, including in the middle of an access.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  localparam int NZONE  = 5;
  localparam int ZIDX_W = 3;
  localparam int MAP_AW = 14;
  // upper (exclusive) limit of zones 0..4; the last limit starts on-chip space
  localparam logic [NZONE-1:0][MAP_AW-1:0] ZONE_LIMIT =
    {14'h3800, 14'h3400, 14'h3000, 14'h0800, 14'h0400};
  typedef logic [ZIDX_W-1:0] zone_idx_t;
endpackage

// File: rtl/dmw_zone_decode.sv
module dmw_zone_decode
  import dmw_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ext_hit,
  output zone_idx_t         zone
);
  always_comb begin
    zone    = '0;
    ext_hit = (MAP_AW'(addr) < ZONE_LIMIT[NZONE-1]);
    for (int i = 0; i < NZONE - 1; i++) begin
      if (MAP_AW'(addr) >= ZONE_LIMIT[i]) zone = zone_idx_t'(i + 1);
    end
  end
endmodule

// File: rtl/dmw_wait_regs.sv
module dmw_wait_regs
  import dmw_pkg::*;
#(
  parameter int WAIT_W     = 3,
  parameter int RESET_WAIT = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  zone_idx_t                     cfg_zone,
  input  logic [WAIT_W-1:0]             cfg_wait,
  output logic [NZONE-1:0][WAIT_W-1:0]  waits
);
  for (genvar g = 0; g < NZONE; g++) begin : g_zone
    logic [WAIT_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      cnt_q <= WAIT_W'(RESET_WAIT);
      else if (cfg_we && (cfg_zone == zone_idx_t'(g))) cnt_q <= cfg_wait;
    end
    assign waits[g] = cnt_q;
  end
endmodule

// File: rtl/dmw_access_seq.sv
module dmw_access_seq #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [WAIT_W-1:0] wait_sel,
  output logic              done
);
  logic [WAIT_W-1:0] elapsed_q;
  logic [WAIT_W-1:0] held_q;
  logic [WAIT_W-1:0] target;

  // first cycle uses the live count; later cycles use the latched one
  assign target = (elapsed_q == '0) ? wait_sel : held_q;
  assign done   = (elapsed_q == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      held_q    <= '0;
    end else if (active) begin
      if (elapsed_q == '0) held_q <= wait_sel;
      elapsed_q <= done ? '0 : elapsed_q + 1'b1;
    end else begin
      elapsed_q <= '0;
    end
  end
endmodule

// File: rtl/dmw_wait_gen.sv
module dmw_wait_gen
  import dmw_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 16,
  parameter int WAIT_W     = 3,
  parameter int RESET_WAIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_zone,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              int_sel,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_sel_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [DATA_W-1:0] ext_dout,
  input  logic [DATA_W-1:0] ext_din
);
  logic                         ext_hit;
  zone_idx_t                    zone;
  logic [NZONE-1:0][WAIT_W-1:0] waits;
  logic [WAIT_W-1:0]            zone_wait;
  logic                         ext_go;
  logic                         seq_done;

  dmw_zone_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(req_addr), .ext_hit(ext_hit), .zone(zone)
  );

  dmw_wait_regs #(.WAIT_W(WAIT_W), .RESET_WAIT(RESET_WAIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_zone(zone_idx_t'(cfg_zone)),
    .cfg_wait(cfg_wait), .waits(waits)
  );

  always_comb begin
    zone_wait = '0;
    for (int i = 0; i < NZONE; i++)
      if (zone == zone_idx_t'(i)) zone_wait = waits[i];
  end

  assign ext_go = req_valid & ext_hit;

  dmw_access_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(ext_go), .wait_sel(zone_wait), .done(seq_done)
  );

  assign req_ready = ~ext_go | seq_done;
  assign int_sel   = req_valid & ~ext_hit;
  assign ext_addr  = req_addr;
  assign ext_sel_n = ~ext_go;
  assign ext_rd_n  = ~(ext_go & ~req_write);
  assign ext_wr_n  = ~(ext_go & req_write);
  assign ext_dout  = (ext_go & req_write) ? req_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= ext_go & ~req_write & seq_done;
      if (ext_go & ~req_write & seq_done) rd_data <= ext_din;
    end
  end
endmodule

// File: rtl/dmw_wait_gen_chk.sv
module dmw_wait_gen_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              int_sel,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              ext_sel_n,
  input logic              ext_rd_n,
  input logic              ext_wr_n,
  input logic [DATA_W-1:0] ext_din
);
  logic [WAIT_W:0] stall_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stall_run <= '0;
    else if (req_valid && !req_ready) stall_run <= stall_run + 1'b1;
    else                              stall_run <= '0;
  end

  p_onchip_no_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= ADDR_W'(14'h3800)) |-> (ext_sel_n && int_sel && req_ready));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  p_strobe_needs_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> !ext_sel_n);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (ext_sel_n && ext_rd_n && ext_wr_n && !int_sel));

  p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run < (WAIT_W + 1)'(2 ** WAIT_W));

  p_read_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !ext_sel_n) |=>
      (rd_valid && rd_data == $past(ext_din)));
endmodule

bind dmw_wait_gen dmw_wait_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) i_chk (.*);

// File: tb/test_dmw_wait_gen.sv
module test_dmw_wait_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_zone = '0;
  logic [2:0]  cfg_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        int_sel, rd_valid, ext_sel_n, ext_rd_n, ext_wr_n;
  logic [15:0] rd_data, ext_dout, ext_din;
  logic [13:0] ext_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_word(logic [13:0] a);
    return {a[5:0], a[13:4]} ^ 16'h3C5A;
  endfunction
  assign ext_din = mem_word(ext_addr);

  dmw_wait_gen i_dmw_wait_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .int_sel(int_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .ext_addr(ext_addr),
    .ext_sel_n(ext_sel_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_dout(ext_dout), .ext_din(ext_din)
  );

  typedef struct {
    logic [13:0] addr;
    bit          wr;
    bit          onchip;
    int          waits;
    logic [15:0] wdata;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  bit          pend_rd = 0;
  logic [15:0] pend_data;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: pushes the expected outcome, then runs the handshake
  task automatic access(logic [13:0] a, bit wr, logic [15:0] d, int w, string tag);
    exp_t e;
    e.addr = a; e.wr = wr; e.onchip = (a >= 14'h3800); e.waits = w; e.wdata = d; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic cfg(logic [2:0] z, logic [2:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_zone = z; cfg_wait = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // monitor: measures each access and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_rd) begin
        pend_rd = 0;
        check(rd_valid === 1'b1, "R7", "rd_valid", rd_valid, 1);
        check(rd_data === pend_data, "R7", "rd_data", rd_data, pend_data);
      end else begin
        check(rd_valid === 1'b0, "R7", "rd_valid idle", rd_valid, 0);
      end
      if (req_valid) begin
        cyc++;
        if (sb_q.size() == 0) begin
          check(0, "R4", "unexpected access", req_addr, 0);
        end else if (!req_ready) begin
          if (!sb_q[0].onchip)
            check(ext_sel_n === 1'b0, "R5", "sel during stall", ext_sel_n, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.waits + 1, e.tag, "access cycles", cyc, e.waits + 1);
          check(ext_addr === e.addr, "R8", "ext_addr", ext_addr, e.addr);
          if (e.onchip) begin
            check(ext_sel_n === 1'b1 && int_sel === 1'b1, "R2", "onchip sel/int",
                  {ext_sel_n, int_sel}, 2'b11);
          end else begin
            check(ext_sel_n === 1'b0 && ext_rd_n === e.wr && ext_wr_n === !e.wr, "R5",
                  "strobes sel/rd/wr", {ext_sel_n, ext_rd_n, ext_wr_n}, {1'b0, e.wr, !e.wr});
            if (e.wr) check(ext_dout === e.wdata, "R8", "ext_dout", ext_dout, e.wdata);
            else begin
              pend_rd = 1; pend_data = mem_word(e.addr);
            end
          end
          cyc = 0;
        end
      end
    end
  end

  task automatic run_tests();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(ext_sel_n && ext_rd_n && ext_wr_n && req_ready, "R5", "reset idle strobes",
          {ext_sel_n, ext_rd_n, ext_wr_n, req_ready}, 4'hF);

    // R3: reset counts are 7 in every zone
    access(14'h0010, 0, 16'h0000, 7, "R3");
    access(14'h1234, 1, 16'hBEEF, 7, "R3");
    access(14'h3500, 0, 16'h0000, 7, "R3");

    // R6 writes, then R1 boundaries of every zone
    cfg(3'd0, 3'd0); cfg(3'd1, 3'd1); cfg(3'd2, 3'd2); cfg(3'd3, 3'd3); cfg(3'd4, 3'd5);
    access(14'h0000, 0, 16'h0,    0, "R1");
    access(14'h03FF, 1, 16'h1111, 0, "R1");
    access(14'h0400, 0, 16'h0,    1, "R1");
    access(14'h07FF, 1, 16'h2222, 1, "R1");
    access(14'h0800, 0, 16'h0,    2, "R1");
    access(14'h2FFF, 1, 16'h3333, 2, "R1");
    access(14'h3000, 0, 16'h0,    3, "R1");
    access(14'h33FF, 1, 16'h4444, 3, "R1");
    access(14'h3400, 0, 16'h0,    5, "R1");
    access(14'h37FF, 1, 16'h5555, 5, "R1");

    // R2: on-chip space completes at once
    access(14'h3800, 0, 16'h0,    0, "R2");
    access(14'h3A00, 1, 16'h6666, 0, "R2");
    access(14'h3FFF, 0, 16'h0,    0, "R2");

    // R6: out-of-range zone index is ignored
    cfg(3'd5, 3'd6); cfg(3'd6, 3'd6); cfg(3'd7, 3'd6);
    for (int z = 0; z < 5; z++) begin
      logic [13:0] a;
      int w;
      a = (z == 0) ? 14'h0100 : (z == 1) ? 14'h0500 : (z == 2) ? 14'h2000 :
          (z == 3) ? 14'h3100 : 14'h3600;
      w = (z == 4) ? 5 : z;
      access(a, 0, 16'h0, w, "R6");
    end

    // R4: zero-wait accesses back to back
    access(14'h0001, 1, 16'hA5A5, 0, "R4");
    access(14'h0002, 0, 16'h0,    0, "R4");

    // R9: change zone 4 during an access
    fork
      access(14'h3700, 0, 16'h0, 5, "R9");
      begin
        repeat (3) @(posedge clk);
        #1 cfg_we = 1'b1; cfg_zone = 3'd4; cfg_wait = 3'd1;
        @(posedge clk); #1 cfg_we = 1'b0;
      end
    join
    access(14'h3700, 1, 16'h7777, 1, "R9");

    repeat (3) @(posedge clk);
    check(sb_q.size() == 0, "R4", "scoreboard drained", sb_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule